// File: doc/BRIEF.md
# Block-Framed SPI Master with Select Hold

This block is an SPI master, serial clock mode 0 (clock idles low, data out changes on falling edges, data in is sampled on rising edges). It moves a block of N words under one chip-select assertion. A block is armed by loading a word count, a target peripheral index, a word length from 8 to 16 bits, an inter-word delay and a hold flag. Outgoing words are pulled from a valid/ready transmit stream, and each received word is pushed out as a one-cycle pulse on a receive stream.

Chip select stays low from before the first serial clock edge of a block until after the last word, whatever the hold flag says. The hold flag only decides the state after the final word. When it is clear, the select rises at once. When it is set, the select stays low into the next block. A later block aimed at the same peripheral continues without a release. A block aimed at another peripheral first forces every select high for at least one serial clock period. This makes long transfers possible, for example a 22-clock converter read built from two 11-bit words.

Top module: `spi_blk_master`

## Requirements
- R1: After reset all `cs_n` bits are 1, `sclk` is 0, `blk_busy` is 0 and `rx_valid` is 0.
- R2: Each word shifts the low `blk_len` bits of the transmit word out on `mosi`, MSB first. `mosi` changes only on falling `sclk` edges and is stable at every rising edge.
- R3: The word length is latched when the block starts and applies to every word of that block. A block of N words produces exactly N×length rising `sclk` edges, and lengths 8, 11 and 16 are all supported.
- R4: Each received word holds the `miso` bits sampled on the rising edges, right-aligned to the word length, with zeros above it. One `rx_valid` pulse is given per word.
- R5: The selected `cs_n` bit goes low before the first rising `sclk` edge and stays low between all words of the block, whether or not hold is set.
- R6: With hold clear, the selected `cs_n` bit is high again when `blk_busy` falls at the end of the block.
- R7: With hold set, the select stays low after the block. A following block to the same index keeps it low throughout, with no rising edge.
- R8: When a held select must give way to a different index, all `cs_n` bits are high for at least one serial clock period (2×CLK_HALF system cycles) before the new select falls.
- R9: An inter-word delay of g adds exactly g serial clock periods (2×CLK_HALF×g system cycles) to the spacing between the last rising edge of one word and the first rising edge of the next, with chip select held low.
- R10: If the transmit stream is empty mid-block, `sclk` stays low and the select stays low until a word arrives, after which the block resumes.
- R11: A block accepts exactly N transmit words and produces exactly N receive words. A start with a count of 0 is ignored: `blk_busy` stays 0 and `cs_n` is unchanged.
- R12: At most one `cs_n` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Arms a block when idle |
| blk_count | input | CNT_W | Words in the block |
| blk_sel | input | SEL_W | Target peripheral index |
| blk_hold | input | 1 | Keep select low after the last word |
| blk_len | input | 5 | Word length in bits (8 to 16) |
| blk_gap | input | GAP_W | Delay between words, in serial clock periods |
| blk_busy | output | 1 | Block in progress |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 16 | Transmit word, low bits used |
| tx_ready | output | 1 | Master takes the word this cycle |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | 16 | Received word, zero-extended |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low peripheral selects |

## Verification
The bench builds the block with CLK_HALF=2, NUM_CS=4, CNT_W=6 and GAP_W=3. A serial clock period is then four system cycles, so gap and release timing can be counted exactly. The four selects let held-select switches and same-select continuation be tried on distinct lines. A 3-bit delay field reaches a gap of three periods, and word lengths of 8, 9, 10, 11, 12 and 16 cover both extremes and the two-word 22-clock case.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_WAITTX,
    ST_XFER,
    ST_GAP
  } blk_state_t;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] w);
    if (w < LEN_W'(8))            return LEN_W'(8);
    else if (w > LEN_W'(WORD_W))  return LEN_W'(WORD_W);
    else                          return w;
  endfunction
endpackage

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int MAXW = 16,
  parameter int HALF = 2,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MAXW-1:0] din,
  input  logic [LENW-1:0] len,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [MAXW-1:0] dout
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [MAXW-1:0] shreg, rxsh;
  logic [LENW-1:0] bits_left;
  logic [HW-1:0]   hcnt;
  logic [LENW-1:0] shamt;

  assign shamt = LENW'(MAXW) - len;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      rxsh      <= '0;
      bits_left <= '0;
      hcnt      <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      dout      <= '0;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        shreg     <= din << shamt;
        mosi      <= din[len-1];
        bits_left <= len;
        rxsh      <= '0;
        hcnt      <= '0;
        sclk      <= 1'b0;
        busy      <= 1'b1;
      end else if (busy) begin
        if (hcnt == HW'(HALF-1)) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rxsh <= {rxsh[MAXW-2:0], miso};
          end else begin
            sclk      <= 1'b0;
            shreg     <= shreg << 1;
            mosi      <= shreg[MAXW-2];
            bits_left <= bits_left - 1'b1;
            if (bits_left == LENW'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
              dout <= rxsh;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  // R2
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  // R4
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              rel_en,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  always_ff @(posedge clk) begin
    if (rst)          cs_n <= '1;
    else if (rel_en)  cs_n <= '1;
    else if (set_en)  cs_n <= ~(NUM_CS'(1) << sel);
  end

  // R12
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
endmodule

// File: rtl/spi_blk_master.sv
module spi_blk_master
  import spi_blk_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int CLK_HALF = 2,
  parameter int CNT_W    = 8,
  parameter int GAP_W    = 4,
  localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [SEL_W-1:0]  blk_sel,
  input  logic              blk_hold,
  input  logic [4:0]        blk_len,
  input  logic [GAP_W-1:0]  blk_gap,
  output logic              blk_busy,
  input  logic              tx_valid,
  input  logic [15:0]       tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [15:0]       rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int PER = 2 * CLK_HALF;
  localparam int SCW = $clog2(PER) + 1;
  localparam int GCW = GAP_W + $clog2(PER) + 1;

  blk_state_t       state;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q, held_sel;
  logic             hold_q, held_q;
  logic [GAP_W-1:0] gap_q;
  logic [LEN_W-1:0] len_q;
  logic [SCW-1:0]   scnt;
  logic [GCW-1:0]   gcnt;

  logic start_ok, need_switch, last_done, cs_set, cs_rel, eng_load;
  logic eng_busy, eng_done;

  always_comb begin
    start_ok    = (state == ST_IDLE) && blk_start && (blk_count != '0);
    need_switch = held_q && (held_sel != blk_sel);
    last_done   = (state == ST_XFER) && eng_done && (cnt_q == CNT_W'(1));
    cs_set      = (start_ok && !need_switch) ||
                  ((state == ST_SWITCH) && (scnt == '0));
    cs_rel      = (start_ok && need_switch) || (last_done && !hold_q);
    eng_load    = (state == ST_WAITTX) && tx_valid;
  end

  assign tx_ready = (state == ST_WAITTX);
  assign blk_busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt_q    <= '0;
      sel_q    <= '0;
      held_sel <= '0;
      hold_q   <= 1'b0;
      held_q   <= 1'b0;
      gap_q    <= '0;
      len_q    <= LEN_W'(8);
      scnt     <= '0;
      gcnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_ok) begin
          cnt_q  <= blk_count;
          sel_q  <= blk_sel;
          hold_q <= blk_hold;
          gap_q  <= blk_gap;
          len_q  <= clamp_len(blk_len);
          scnt   <= SCW'(PER - 1);
          if (need_switch) begin
            held_q <= 1'b0;
            state  <= ST_SWITCH;
          end else begin
            state  <= ST_WAITTX;
          end
        end
        ST_SWITCH: begin
          if (scnt == '0) state <= ST_WAITTX;
          else            scnt  <= scnt - 1'b1;
        end
        ST_WAITTX: if (tx_valid) state <= ST_XFER;
        ST_XFER: if (eng_done) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            state    <= ST_IDLE;
            held_q   <= hold_q;
            held_sel <= sel_q;
          end else if (gap_q != '0) begin
            gcnt  <= GCW'(gap_q) * GCW'(PER) - 1'b1;
            state <= ST_GAP;
          end else begin
            state <= ST_WAITTX;
          end
        end
        ST_GAP: begin
          if (gcnt == '0) state <= ST_WAITTX;
          else            gcnt  <= gcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  spi_word_engine #(.MAXW(WORD_W), .HALF(CLK_HALF), .LENW(LEN_W)) u_eng (
    .clk  (clk),
    .rst  (rst),
    .load (eng_load),
    .din  (tx_data),
    .len  (len_q),
    .miso (miso),
    .sclk (sclk),
    .mosi (mosi),
    .busy (eng_busy),
    .done (eng_done),
    .dout (rx_data)
  );

  assign rx_valid = eng_done;

  spi_cs_ctrl #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .clk    (clk),
    .rst    (rst),
    .set_en (cs_set),
    .rel_en (cs_rel),
    .sel    (cs_set && start_ok ? blk_sel : sel_q),
    .cs_n   (cs_n)
  );

  // R10
  stall_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITTX) |-> (!sclk && !eng_busy));

  // R5
  sel_low_in_block_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITTX || state == ST_XFER || state == ST_GAP) |-> !cs_n[sel_q]);

  // R8
  switch_all_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWITCH) |-> (&cs_n));

  // R4
  rx_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> len_q) == 16'h0));

  // R11
  zero_count_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && blk_start && blk_count == '0) |=> (state == ST_IDLE && $stable(cs_n)));
endmodule

// File: tb/tb_spi_blk_master.sv
`timescale 1ns/1ps
module tb_spi_blk_master;
  localparam int NUM_CS = 4;
  localparam int HALF   = 2;
  localparam int CNT_W  = 6;
  localparam int GAP_W  = 3;
  localparam int PER    = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_start = 1'b0;
  logic [CNT_W-1:0] blk_count = '0;
  logic [1:0] blk_sel = '0;
  logic blk_hold = 1'b0;
  logic [4:0] blk_len = 5'd8;
  logic [GAP_W-1:0] blk_gap = '0;
  logic blk_busy;
  logic tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_ready, rx_valid;
  logic [15:0] rx_data;
  logic sclk, mosi;
  logic miso = 1'b0;
  logic [NUM_CS-1:0] cs_n;

  always #10 clk = ~clk;

  spi_blk_master #(.NUM_CS(NUM_CS), .CLK_HALF(HALF), .CNT_W(CNT_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .blk_count(blk_count),
    .blk_sel(blk_sel), .blk_hold(blk_hold), .blk_len(blk_len), .blk_gap(blk_gap),
    .blk_busy(blk_busy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  int n_tests = 0, n_fail = 0;
  int cur_len = 8;
  int rc = 0;
  logic [15:0] cap [8];
  logic [15:0] tw [8];
  logic [15:0] sw [8];
  logic [15:0] rx_log [8];
  realtime rt [64];
  int rx_n = 0;
  int rises [NUM_CS];
  int allhigh_run = 0, last_run = 0, multi_low = 0;
  logic [NUM_CS-1:0] prev_cs = '1;
  int base_space = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(input int len);
    return 16'((17'h1 << len) - 1);
  endfunction

  // serial slave model
  always @(posedge sclk) begin
    int w;
    w = rc / cur_len;
    if (w < 8) cap[w] = {cap[w][14:0], mosi};
    if (rc < 64) rt[rc] = $realtime;
    rc++;
  end
  always @(negedge sclk) begin
    int w, b;
    w = rc / cur_len;
    b = rc % cur_len;
    if (w < 8) miso = sw[w][cur_len-1-b];
  end

  // port monitors
  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_n < 8) rx_log[rx_n] = rx_data;
      rx_n++;
    end
    for (int k = 0; k < NUM_CS; k++)
      if (cs_n[k] && !prev_cs[k]) rises[k]++;
    if (&prev_cs && !(&cs_n)) last_run = allhigh_run;
    if (&cs_n) allhigh_run++; else allhigh_run = 0;
    if ($countones(~cs_n) > 1) multi_low++;
    prev_cs = cs_n;
  end

  task automatic run_block(input int len, input int n, input int sel, input bit hold,
                           input int gap, input int stall_after, input int stall_cyc);
    int r0;
    for (int i = 0; i < 8; i++) begin
      tw[i]  = 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(len);
      sw[i]  = 16'h3C5A + 16'(i * 16'h0F1E);
      cap[i] = '0;
    end
    cur_len = len;
    rc = 0;
    rx_n = 0;
    r0 = rises[sel];
    miso = sw[0][len-1];
    @(negedge clk);
    blk_start = 1'b1; blk_count = CNT_W'(n); blk_sel = 2'(sel);
    blk_hold = hold; blk_len = 5'(len); blk_gap = GAP_W'(gap);
    @(negedge clk);
    blk_start = 1'b0;
    check(blk_busy == 1'b1, "R11 busy after start", int'(blk_busy), 1);
    for (int i = 0; i < n; i++) begin
      tx_valid = 1'b1;
      tx_data  = tw[i];
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      if (i == stall_after && stall_cyc > 0) begin
        int rc0;
        while (rx_n < i + 1) @(negedge clk);
        rc0 = rc;
        repeat (stall_cyc) @(negedge clk);
        check(rc == rc0 && sclk == 1'b0, "R10 sclk idle while empty", rc, rc0);
        check(cs_n[sel] == 1'b0, "R10 select held while empty", int'(cs_n[sel]), 0);
      end
    end
    while (blk_busy) @(negedge clk);
    @(negedge clk);
    check(rx_n == n, "R11 receive word count", rx_n, n);
    check(rc == n * len, "R3 rising edges per block", rc, n * len);
    for (int i = 0; i < n && i < 8; i++) begin
      check(cap[i] == (tw[i] & msk(len)), "R2 mosi word", int'(cap[i]), int'(tw[i] & msk(len)));
      check(rx_log[i] == (sw[i] & msk(len)), "R4 received word", int'(rx_log[i]), int'(sw[i] & msk(len)));
    end
    check(rises[sel] - r0 == (hold ? 0 : 1), "R5 select rises only at block end",
          rises[sel] - r0, hold ? 0 : 1);
    if (hold) check(cs_n[sel] == 1'b0, "R7 select kept low", int'(cs_n[sel]), 0);
    else      check(cs_n[sel] == 1'b1, "R6 select released", int'(cs_n[sel]), 1);
  endtask

  task automatic test_reset();
    check(cs_n == '1 && sclk == 1'b0, "R1 reset selects and clock", int'(cs_n), 'hF);
    check(blk_busy == 1'b0 && rx_valid == 1'b0, "R1 reset busy and rx", int'({blk_busy, rx_valid}), 0);
  endtask

  task automatic test_len8();
    run_block(8, 3, 0, 1'b0, 0, -1, 0);
    base_space = int'((rt[8] - rt[7]) / 20.0);
  endtask

  task automatic test_len16();
    run_block(16, 2, 1, 1'b0, 0, -1, 0);
  endtask

  task automatic test_len11_pair();
    run_block(11, 2, 2, 1'b0, 0, -1, 0);
    check(rc == 22, "R3 two 11-bit words give 22 clocks", rc, 22);
  endtask

  task automatic test_gap();
    int sp;
    run_block(8, 2, 1, 1'b0, 3, -1, 0);
    sp = int'((rt[8] - rt[7]) / 20.0);
    check(sp - base_space == 3 * PER, "R9 inter-word delay", sp - base_space, 3 * PER);
  endtask

  task automatic test_stall();
    run_block(12, 3, 3, 1'b0, 0, 0, 40);
  endtask

  task automatic test_hold_same();
    run_block(10, 2, 3, 1'b1, 0, -1, 0);
    run_block(10, 1, 3, 1'b0, 0, -1, 0);
    check(rises[3] > 0, "R7 same-select continuation released at end", rises[3], 1);
  endtask

  task automatic test_hold_switch();
    run_block(9, 1, 0, 1'b1, 0, -1, 0);
    run_block(12, 1, 2, 1'b0, 0, -1, 0);
    check(last_run >= PER, "R8 all selects high before switch", last_run, PER);
    check(cs_n[0] == 1'b1, "R8 old select released", int'(cs_n[0]), 1);
  endtask

  task automatic test_zero_count();
    @(negedge clk);
    blk_start = 1'b1; blk_count = '0; blk_sel = 2'd1; blk_hold = 1'b0;
    @(negedge clk);
    blk_start = 1'b0;
    repeat (10) @(negedge clk);
    check(blk_busy == 1'b0, "R11 zero count ignored busy", int'(blk_busy), 0);
    check(cs_n == '1, "R11 zero count ignored selects", int'(cs_n), 'hF);
  endtask

  initial begin
    for (int k = 0; k < NUM_CS; k++) rises[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_len8();
    test_len16();
    test_len11_pair();
    test_gap();
    test_stall();
    test_zero_count();
    test_hold_same();
    test_hold_switch();
    check(multi_low == 0, "R12 at most one select low", multi_low, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule